// File: doc/BRIEF.md
# Two-Channel Timer Start/Stop Controller

This block is the run-control front end of a two-channel 16-bit up-counting timer. Each channel has a start bit and a stop-select bit in a shared 8-bit control register. With stop-select low, a started channel runs as a one-shot. Software cannot stop it: it halts by itself when its counter equals its compare value. With stop-select high, the channel runs freely. Its counter clears to zero on every compare match, and software can halt it. A software stop only takes effect when stop-select was already high before the stopping write.

A simple register bus reaches all the registers. A peripheral enable input gates the whole block. While the enable is low, every write is dropped, every read returns zero, and all state holds. The configuration registers are the output-action register and the output-enable register. They accept writes only while both channels are stopped. On each compare match a channel pulses a flag for one clock and applies its output action to its output level. On any stop the output pin keeps its last level. A bus write to a counter beats both the clear and the increment that the counter would otherwise take in that cycle.

Each channel is a three-state machine: CH_IDLE, CH_ONESHOT and CH_FREE. It has these transitions:
- **start**: CH_IDLE to CH_ONESHOT or CH_FREE, chosen by the stop-select value written with the start bit.
- **match stop**: CH_ONESHOT to CH_IDLE.
- **soft stop**: CH_FREE to CH_IDLE, on a write with start at 0.
- **reselect**: CH_ONESHOT to CH_FREE, or back, when stop-select is rewritten during a run.

Top module: `tmr_startstop`

## Requirements
- R1: While `periph_en` is 0, bus writes change no register, `rd_data` reads 0 for every address, and all counters and states hold.
- R2: After reset every register, including the control register (address 0), the compare and counter registers and the pins, reads 0.
- R3: The register map is as follows. Any address outside it reads 0.

  | Address | Register | Contents |
  |---|---|---|
  | 0 | Control, 8 bits | bit0/bit1 = start bit of channel 0/1 (live value); bit2/bit3 = stop-select of channel 0/1 |
  | 1 | Output action | bits[1:0] = channel 0, bits[3:2] = channel 1 |
  | 2 | Output enable | bits[1:0] |
  | 3, 4 | Compare, channels 0 and 1 | |
  | 5, 6 | Counter, channels 0 and 1 | |

  A running counter increments by one per clock and wraps from FFFFh to 0000h. A stopped counter holds its value.
- R4: A channel started with stop-select 0 counts until its counter equals its compare value. On the next clock its start bit reads 0 and its counter reads 0.
- R5: While a channel runs with stop-select 0, a write of 0 to its start bit is ignored, and the start bit keeps reading 1.
- R6: One write that sets stop-select to 1 and start to 0 on a channel running with stop-select 0 keeps it counting. A later write of start 0 stops it, and its counter then holds.
- R7: A channel running with stop-select 1 clears its counter to 0 on the clock after a compare match and keeps counting.
- R8: `match_pulse[i]` is 1 during the cycle in which running channel i's counter equals its compare value. On the following edge the output level is updated according to the action code: 0 = unchanged, 1 = low, 2 = high, 3 = toggle. `chan_out[i]` equals the output-enable bit i ANDed with that level.
- R9: A software stop leaves `chan_out` unchanged.
- R10: A counter write in the same cycle as a match clear or an increment loads the written value.
- R11: While either start bit is 1, writes to the output-action and output-enable registers are dropped. The control, compare and counter registers still accept writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable; gates bus access and counting |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, combinational from address |
| match_pulse | output | 2 | Per-channel compare-match flag |
| chan_out | output | 2 | Per-channel output pins |

## Verification
A wrong channel state shows up immediately on the control register read-back. The start bit is the live run state, so a missed match stop or an accepted illegal stop reads wrong in the next cycle. The counter then diverges, and it shows on the counter read within one clock. A wrong output level or missed match appears on `chan_out` one clock after the match cycle, and a toggling output makes every lost or extra match visible. A protection or gating fault leaves a changed configuration register that reads back wrong on the next access.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ONESHOT = 2'd1,
        CH_FREE    = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } out_act_e;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_ACT  = 1;
    localparam int ADDR_OE   = 2;
    localparam int ADDR_CMP0 = 3;
endpackage

// File: rtl/tss_chan.sv
module tss_chan
    import tss_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ctrl_we,
    input  logic          start_wr,
    input  logic          sel_wr,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [CW-1:0] cmp,
    input  logic [1:0]    action,
    output logic          run,
    output logic          sel,
    output logic [CW-1:0] cnt,
    output logic          match,
    output logic          level
);
    ch_state_e     state_q, state_d;
    logic          sel_q, sel_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          level_q, level_d;
    logic          running;

    assign running = (state_q != CH_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            sel_q   <= 1'b0;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (en) begin
            state_q <= state_d;
            sel_q   <= sel_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    // next state: decisions use the stop-select held before this write
    always_comb begin
        sel_d   = ctrl_we ? sel_wr : sel_q;
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctrl_we && start_wr)
                    state_d = sel_d ? CH_FREE : CH_ONESHOT;
            end
            CH_ONESHOT: begin
                if (match)
                    state_d = CH_IDLE;
                else
                    state_d = sel_d ? CH_FREE : CH_ONESHOT;
            end
            CH_FREE: begin
                if (ctrl_we && !start_wr)
                    state_d = CH_IDLE;
                else
                    state_d = sel_d ? CH_FREE : CH_ONESHOT;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs and datapath
    always_comb begin
        match = en && running && (cnt_q == cmp);
        if (cnt_we)
            cnt_d = cnt_wdata;
        else if (running)
            cnt_d = match ? '0 : cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
        level_d = level_q;
        if (match) begin
            unique case (out_act_e'(action))
                ACT_NONE:   level_d = level_q;
                ACT_LOW:    level_d = 1'b0;
                ACT_HIGH:   level_d = 1'b1;
                ACT_TOGGLE: level_d = ~level_q;
                default:    level_d = level_q;
            endcase
        end
        run   = running;
        sel   = sel_q;
        cnt   = cnt_q;
        level = level_q;
    end

    p_oneshot_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == CH_ONESHOT && !match |=> run);
    p_match_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == CH_ONESHOT && match |=> state_q == CH_IDLE);
    p_combined_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == CH_ONESHOT && !match && ctrl_we && sel_wr && !start_wr
        |=> state_q == CH_FREE);
    p_soft_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == CH_FREE && ctrl_we && !start_wr && !match
        |=> state_q == CH_IDLE && $stable(level_q));
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en && cnt_we |=> cnt_q == $past(cnt_wdata));
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == CH_IDLE && !cnt_we |=> $stable(cnt_q));
    p_gate_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q) && $stable(state_q));
endmodule

// File: rtl/tss_regs.sv
module tss_regs
    import tss_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 2,
    parameter int AW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    input  logic [NCH-1:0]    run,
    input  logic [NCH-1:0]    sel,
    input  logic [NCH*CW-1:0] cnt_flat,
    output logic [CW-1:0]     rdata,
    output logic              ctrl_we,
    output logic [NCH-1:0]    start_wr,
    output logic [NCH-1:0]    sel_wr,
    output logic [NCH-1:0]    cnt_we,
    output logic [NCH*CW-1:0] cmp_flat,
    output logic [2*NCH-1:0]  act_flat,
    output logic [NCH-1:0]    oe
);
    localparam int CNT_BASE = ADDR_CMP0 + NCH;

    logic [2*NCH-1:0] act_q;
    logic [NCH-1:0]   oe_q;
    logic             any_run;
    logic             wr_ok;
    logic             cfg_ok;

    assign any_run = |run;
    assign wr_ok   = en && wr;
    assign cfg_ok  = wr_ok && !any_run;
    assign ctrl_we = wr_ok && (addr == AW'(ADDR_CTRL));

    // configuration registers, write-protected while any channel runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            oe_q  <= '0;
        end else begin
            if (cfg_ok && addr == AW'(ADDR_ACT))
                act_q <= wdata[2*NCH-1:0];
            if (cfg_ok && addr == AW'(ADDR_OE))
                oe_q <= wdata[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CW-1:0] cmp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp_q <= '0;
            else if (wr_ok && addr == AW'(ADDR_CMP0 + i))
                cmp_q <= wdata;
        end
        assign cmp_flat[i*CW +: CW] = cmp_q;
        assign cnt_we[i]   = wr_ok && (addr == AW'(CNT_BASE + i));
        assign start_wr[i] = wdata[i];
        assign sel_wr[i]   = wdata[NCH + i];

        p_gate_cmp_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(cmp_q));
    end

    assign act_flat = act_q;
    assign oe       = oe_q;

    // read mux
    always_comb begin
        rdata = '0;
        if (en) begin
            if (addr == AW'(ADDR_CTRL)) begin
                rdata[NCH-1:0]     = run;
                rdata[2*NCH-1:NCH] = sel;
            end else if (addr == AW'(ADDR_ACT)) begin
                rdata[2*NCH-1:0] = act_q;
            end else if (addr == AW'(ADDR_OE)) begin
                rdata[NCH-1:0] = oe_q;
            end else begin
                for (int k = 0; k < NCH; k++) begin
                    if (addr == AW'(ADDR_CMP0 + k))
                        rdata = cmp_flat[k*CW +: CW];
                    if (addr == AW'(CNT_BASE + k))
                        rdata = cnt_flat[k*CW +: CW];
                end
            end
        end
    end

    p_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        any_run |=> $stable(act_q) && $stable(oe_q));
    p_gate_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(act_q) && $stable(oe_q));
endmodule

// File: rtl/tmr_startstop.sv
module tmr_startstop
    import tss_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 2,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           periph_en,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  rd_data,
    output logic [NCH-1:0] match_pulse,
    output logic [NCH-1:0] chan_out
);
    logic [NCH-1:0]    run, sel, start_wr, sel_wr, cnt_we, oe, level;
    logic [NCH*CW-1:0] cnt_flat, cmp_flat;
    logic [2*NCH-1:0]  act_flat;
    logic              ctrl_we;

    tss_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (periph_en),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .run      (run),
        .sel      (sel),
        .cnt_flat (cnt_flat),
        .rdata    (rd_data),
        .ctrl_we  (ctrl_we),
        .start_wr (start_wr),
        .sel_wr   (sel_wr),
        .cnt_we   (cnt_we),
        .cmp_flat (cmp_flat),
        .act_flat (act_flat),
        .oe       (oe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tss_chan #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (periph_en),
            .ctrl_we   (ctrl_we),
            .start_wr  (start_wr[i]),
            .sel_wr    (sel_wr[i]),
            .cnt_we    (cnt_we[i]),
            .cnt_wdata (bus_wdata),
            .cmp       (cmp_flat[i*CW +: CW]),
            .action    (act_flat[2*i +: 2]),
            .run       (run[i]),
            .sel       (sel[i]),
            .cnt       (cnt_flat[i*CW +: CW]),
            .match     (match_pulse[i]),
            .level     (level[i])
        );
        assign chan_out[i] = oe[i] & level[i];
    end

    p_pulse_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse & ~run) == '0);
endmodule

// File: tb/tmr_startstop_test.sv
module tmr_startstop_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        periph_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic [1:0]  match_pulse;
    logic [1:0]  chan_out;

    int n_chk = 0;
    int n_bad = 0;

    tmr_startstop uut (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .match_pulse(match_pulse), .chan_out(chan_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = rd_data;
    endtask

    // free-running model: m clocks from count c with compare cmp
    function automatic logic [15:0] free_step(input logic [15:0] c, input logic [15:0] cmp,
                                              input int m, output int hits);
        logic [15:0] v = c;
        hits = 0;
        for (int s = 0; s < m; s++) begin
            if (v == cmp) begin v = 16'h0; hits++; end
            else v = v + 16'h1;
        end
        return v;
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        logic        lvl0, lvl1;
        int          hits;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R2 reset read", v, 16'h0);
        end
        check("R2 pins", {14'h0, chan_out}, 16'h0);

        // R1 gating
        periph_en = 1'b0;
        wr(3'd3, 16'h0005);
        periph_en = 1'b1;
        rd(3'd3, v);
        check("R1 write ignored", v, 16'h0);
        wr(3'd3, 16'h0007);
        periph_en = 1'b0;
        rd(3'd3, v);
        check("R1 read zero", v, 16'h0);
        periph_en = 1'b1;
        rd(3'd3, v);
        check("R1 value kept", v, 16'h0007);

        // R4 R8 one-shot match on ch0, action high
        wr(3'd1, 16'h0002);
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h0004);
        wr(3'd5, 16'h0000);
        wr(3'd0, 16'h0001);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 match pulse", {14'h0, match_pulse}, 16'h0001);
        rd(3'd0, v);
        check("R4 stopped", v, 16'h0000);
        rd(3'd5, v);
        check("R4 count cleared", v, 16'h0000);
        check("R8 out high", {15'h0, chan_out[0]}, 16'h1);

        // R5 R6 R9 on ch0: compare far away
        wr(3'd1, 16'h0003);
        wr(3'd3, 16'd200);
        wr(3'd0, 16'h0001);
        wr(3'd0, 16'h0000);
        rd(3'd0, v);
        check("R5 stop ignored", v, 16'h0001);
        wr(3'd0, 16'h0004);
        rd(3'd0, v);
        check("R6 combined keeps run", v, 16'h0005);
        rd(3'd5, v);
        rd(3'd5, v2);
        check("R3 counting", v2, v + 16'h1);
        lvl0 = chan_out[0];
        wr(3'd0, 16'h0004);
        rd(3'd0, v);
        check("R6 soft stop", v, 16'h0004);
        rd(3'd5, v);
        repeat (3) @(posedge clk);
        rd(3'd5, v2);
        check("R6 count held", v2, v);
        check("R9 out held", {15'h0, chan_out[0]}, {15'h0, lvl0});

        // R11 protection while ch1 runs
        wr(3'd4, 16'd1000);
        wr(3'd0, 16'h000E);
        wr(3'd1, 16'h0000);
        rd(3'd1, v);
        check("R11 action protected", v, 16'h0003);
        wr(3'd2, 16'h0000);
        rd(3'd2, v);
        check("R11 oe protected", v, 16'h0003);
        wr(3'd3, 16'h0009);
        rd(3'd3, v);
        check("R11 compare writable", v, 16'h0009);
        wr(3'd0, 16'h000C);
        wr(3'd1, 16'h000F);
        rd(3'd1, v);
        check("R11 accepted when idle", v, 16'h000F);

        // R10 write beats match clear, R7 free mode
        wr(3'd3, 16'h0003);
        wr(3'd5, 16'h0000);
        wr(3'd0, 16'h000D);
        repeat (3) @(posedge clk);
        wr(3'd5, 16'h0055);
        rd(3'd5, v);
        check("R10 write wins", v, 16'h0055);
        rd(3'd5, v);
        check("R10 count from written", v, 16'h0056);
        wr(3'd0, 16'h000C);

        // R3 wrap
        wr(3'd3, 16'h0005);
        wr(3'd5, 16'hFFFF);
        wr(3'd0, 16'h000D);
        @(posedge clk);
        rd(3'd5, v);
        check("R3 wrap", v, 16'h0000);
        wr(3'd0, 16'h000C);

        // R7 R8 random free-running runs with toggle action
        for (int it = 0; it < 40; it++) begin
            int          ch = int'($urandom_range(0, 1));
            int          m  = int'($urandom_range(1, 40));
            logic [15:0] c0 = 16'($urandom_range(0, 15));
            logic [15:0] cm = 16'($urandom_range(0, 15));
            logic [15:0] expc;
            @(negedge clk);
            lvl1 = chan_out[ch];
            wr(3'(5 + ch), c0);
            wr(3'(3 + ch), cm);
            wr(3'd0, 16'h000C | 16'(1 << ch));
            repeat (m) @(posedge clk);
            expc = free_step(c0, cm, m, hits);
            rd(3'(5 + ch), v);
            check("R7 free count", v, expc);
            check("R8 toggle level", {15'h0, chan_out[ch]},
                  {15'h0, lvl1 ^ hits[0]});
            wr(3'd0, 16'h000C);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule